// File: doc/BRIEF.md
# Interrupt Cause and Mask Register Bank

This block gathers hardware event pulses into a sticky cause register, applies a per-source mask and raises one interrupt request line. Software reaches the block through a small word-addressed register port that has a write strobe and a read strobe. Through that port it programs, for each source, whether a pending cause is cleared by writing a one to it or by reading it.

Software can also raise a cause itself through a set-only register. The mask can be written whole, or bits can be set or cleared one at a time without a read-modify-write sequence. A given source uses the same bit position in all seven registers. The word offsets are fixed because software decodes them: 0 clear-mode, 1 cause, 2 masked cause, 3 cause set, 4 mask, 5 mask set, 6 mask clear.

Top module: `irq_cause_bank`

## Requirements
- R1: After a synchronous reset, the cause and clear-mode registers read 0, the mask (offset 4) reads all ones, and `irq_out` is 0.
- R2: An event bit high at a clock edge sets its cause bit, which stays set until it is cleared. `irq_out` is the OR of cause AND NOT mask and reflects the registers from the edge on which they change.
- R3: The mask (offset 4) is read and written directly. A mask bit of 1 blocks its source. The masked cause (offset 2) reads cause AND NOT mask.
- R4: Writing the mask set register (offset 5) sets the mask bits where the data is 1 and leaves all other mask bits unchanged.
- R5: Writing the mask clear register (offset 6) clears the mask bits where the data is 1 and leaves all other mask bits unchanged.
- R6: Writing the cause set register (offset 3) sets the cause bits where the data is 1. Reads of offsets 3, 5, 6 and 7 return 0.
- R7: The clear-mode register (offset 0) is read and written directly. A bit of 0 selects write-one-to-clear: writing a 1 to that bit at offset 1 or 2 clears the cause bit, and reads leave it unchanged.
- R8: A clear-mode bit of 1 selects clear-on-read: a read of offset 1 or 2 clears that cause bit, and writes to offsets 1 and 2 leave it unchanged.
- R9: A clear-on-read access clears only the bits returned by that read. A read of offset 2 therefore leaves masked cause bits set.
- R10: When an event and a clear (by write or by read) hit the same bit at the same edge, the bit ends up set.
- R11: Read data is registered. It appears on `reg_rdata` after the clock edge that sampled `reg_rd` and shows the register contents from before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 3 | Word offset of the register accessed |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rd | input | 1 | Read strobe |
| reg_rdata | output | 32 | Registered read data |
| evt_in | input | 32 | Hardware event inputs, one per source |
| irq_out | output | 1 | Interrupt request |

## Verification
All register effects take hold at the edge that samples the strobe or the event. A read issued on the following cycle therefore sees them, and `irq_out` is valid one edge after an event. Read data appears after the edge that samples `reg_rd`, so the bench raises the strobe on a falling edge and samples `reg_rdata` on the next falling edge. For the same-edge collisions, the bench applies the event together with the clearing strobe in a single cycle. It then checks both the value returned by that read and the value returned by the read after it.

// File: rtl/irqbank_pkg.sv
package irqbank_pkg;

    localparam int REG_AW = 3;

    typedef enum logic [REG_AW-1:0] {
        OFS_MODE     = 3'd0,
        OFS_CAUSE    = 3'd1,
        OFS_MASKED   = 3'd2,
        OFS_SET      = 3'd3,
        OFS_MASK     = 3'd4,
        OFS_MASK_SET = 3'd5,
        OFS_MASK_CLR = 3'd6
    } reg_ofs_e;

    typedef struct packed {
        logic mode_we;
        logic cause_we;
        logic masked_we;
        logic set_we;
        logic mask_we;
        logic mask_set_we;
        logic mask_clr_we;
    } wr_dec_t;

    typedef struct packed {
        logic cause_rd;
        logic masked_rd;
    } rd_dec_t;

    function automatic wr_dec_t decode_wr(input logic we, input logic [REG_AW-1:0] a);
        wr_dec_t d;
        d = '0;
        if (we) begin
            case (reg_ofs_e'(a))
                OFS_MODE:     d.mode_we     = 1'b1;
                OFS_CAUSE:    d.cause_we    = 1'b1;
                OFS_MASKED:   d.masked_we   = 1'b1;
                OFS_SET:      d.set_we      = 1'b1;
                OFS_MASK:     d.mask_we     = 1'b1;
                OFS_MASK_SET: d.mask_set_we = 1'b1;
                OFS_MASK_CLR: d.mask_clr_we = 1'b1;
                default:      d = '0;
            endcase
        end
        return d;
    endfunction

    function automatic rd_dec_t decode_rd(input logic re, input logic [REG_AW-1:0] a);
        rd_dec_t d;
        d.cause_rd  = re && (a == OFS_CAUSE);
        d.masked_rd = re && (a == OFS_MASKED);
        return d;
    endfunction

endpackage

// File: rtl/irq_cause_store.sv
module irq_cause_store #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] evt,
    input  logic [W-1:0] set_bits,
    input  logic [W-1:0] w1c_bits,
    input  logic [W-1:0] cor_bits,
    input  logic [W-1:0] mode,
    output logic [W-1:0] cause_q
);
    logic [W-1:0] clr_bits;
    logic [W-1:0] cause_d;

    always_comb begin
        clr_bits = (w1c_bits & ~mode) | (cor_bits & mode);
        cause_d  = (cause_q & ~clr_bits) | set_bits | evt;
    end

    always_ff @(posedge clk) begin
        if (rst) cause_q <= '0;
        else     cause_q <= cause_d;
    end

    // R10
    evt_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (evt != '0) |=> ((cause_q & $past(evt)) == $past(evt)));

    // R2
    cause_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (evt == '0 && set_bits == '0 && w1c_bits == '0 && cor_bits == '0) |=> $stable(cause_q));

    // R6
    cause_set_chk: assert property (@(posedge clk) disable iff (rst)
        (set_bits != '0) |=> ((cause_q & $past(set_bits)) == $past(set_bits)));
endmodule

// File: rtl/irq_mask_store.sv
module irq_mask_store #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         mode_we,
    input  logic         mask_we,
    input  logic         mask_set_we,
    input  logic         mask_clr_we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] mode_q,
    output logic [W-1:0] mask_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= '0;
            mask_q <= '1;
        end else begin
            if (mode_we) mode_q <= wdata;
            if (mask_we)          mask_q <= wdata;
            else if (mask_set_we) mask_q <= mask_q | wdata;
            else if (mask_clr_we) mask_q <= mask_q & ~wdata;
        end
    end

    // R4
    mask_set_chk: assert property (@(posedge clk) disable iff (rst)
        mask_set_we |=> ((mask_q & $past(wdata)) == $past(wdata)));

    // R5
    mask_clr_chk: assert property (@(posedge clk) disable iff (rst)
        mask_clr_we |=> ((mask_q & $past(wdata)) == '0));

    // R4
    mask_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (mask_set_we || mask_clr_we) |=> ((mask_q & ~$past(wdata)) == ($past(mask_q) & ~$past(wdata))));
endmodule

// File: rtl/irq_read_port.sv
module irq_read_port #(
    parameter int W  = 32,
    parameter int AW = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rd_en,
    input  logic [AW-1:0] addr,
    input  logic [W-1:0]  mode_q,
    input  logic [W-1:0]  cause_q,
    input  logic [W-1:0]  masked,
    input  logic [W-1:0]  mask_q,
    output logic [W-1:0]  rdata
);
    import irqbank_pkg::*;

    logic [W-1:0] sel;

    always_comb begin
        case (reg_ofs_e'(addr))
            OFS_MODE:   sel = mode_q;
            OFS_CAUSE:  sel = cause_q;
            OFS_MASKED: sel = masked;
            OFS_MASK:   sel = mask_q;
            default:    sel = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)        rdata <= '0;
        else if (rd_en) rdata <= sel;
    end

    // R6
    wo_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && (addr == OFS_SET || addr == OFS_MASK_SET || addr == OFS_MASK_CLR || addr == 3'd7))
        |=> (rdata == '0));

    // R11
    rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rdata));
endmodule

// File: rtl/irq_cause_bank.sv
module irq_cause_bank #(
    parameter int W = 32
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [irqbank_pkg::REG_AW-1:0] reg_addr,
    input  logic                          reg_wr,
    input  logic [W-1:0]                  reg_wdata,
    input  logic                          reg_rd,
    output logic [W-1:0]                  reg_rdata,
    input  logic [W-1:0]                  evt_in,
    output logic                          irq_out
);
    import irqbank_pkg::*;

    wr_dec_t      wd;
    rd_dec_t      rdd;
    logic [W-1:0] mode_q, mask_q, cause_q, masked;
    logic [W-1:0] set_bits, w1c_bits, cor_bits;

    always_comb begin
        wd       = decode_wr(reg_wr, reg_addr);
        rdd      = decode_rd(reg_rd, reg_addr);
        masked   = cause_q & ~mask_q;
        set_bits = wd.set_we ? reg_wdata : '0;
        w1c_bits = (wd.cause_we || wd.masked_we) ? reg_wdata : '0;
        if (rdd.cause_rd)       cor_bits = cause_q;
        else if (rdd.masked_rd) cor_bits = masked;
        else                    cor_bits = '0;
    end

    irq_mask_store #(.W(W)) u_mask (
        .clk(clk), .rst(rst),
        .mode_we(wd.mode_we), .mask_we(wd.mask_we),
        .mask_set_we(wd.mask_set_we), .mask_clr_we(wd.mask_clr_we),
        .wdata(reg_wdata), .mode_q(mode_q), .mask_q(mask_q)
    );

    irq_cause_store #(.W(W)) u_cause (
        .clk(clk), .rst(rst), .evt(evt_in), .set_bits(set_bits),
        .w1c_bits(w1c_bits), .cor_bits(cor_bits), .mode(mode_q),
        .cause_q(cause_q)
    );

    irq_read_port #(.W(W), .AW(REG_AW)) u_rd (
        .clk(clk), .rst(rst), .rd_en(reg_rd), .addr(reg_addr),
        .mode_q(mode_q), .cause_q(cause_q), .masked(masked), .mask_q(mask_q),
        .rdata(reg_rdata)
    );

    assign irq_out = |masked;

    // R8
    cor_write_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == OFS_CAUSE && !reg_rd) |=>
        ((cause_q & $past(mode_q)) == ($past(cause_q) & $past(mode_q)) | ($past(cause_q | evt_in) & $past(mode_q))));

    // R7
    w1c_read_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_rd && !reg_wr) |=> ((cause_q & ~$past(mode_q)) & $past(cause_q)) == ($past(cause_q) & ~$past(mode_q)));

    // R1
    rst_mask_chk: assert property (@(posedge clk) $past(rst) |-> (mask_q == '1 && cause_q == '0 && !irq_out));
endmodule

// File: tb/sim_irq_cause_bank.sv
module sim_irq_cause_bank;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  addr = '0;
    logic        wr = 1'b0, rd = 1'b0;
    logic [31:0] wdata = '0, evt = '0;
    logic [31:0] rdata;
    logic        irq;
    logic [31:0] v;
    int nchk = 0, nerr = 0;
    bit done = 0;

    always #2 clk = ~clk;

    irq_cause_bank #(.W(32)) u0 (
        .clk(clk), .rst(rst), .reg_addr(addr), .reg_wr(wr), .reg_wdata(wdata),
        .reg_rd(rd), .reg_rdata(rdata), .evt_in(evt), .irq_out(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic do_rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk); addr = a; rd = 1'b1;
        @(negedge clk); rd = 1'b0; d = rdata;
    endtask

    task automatic do_wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk); addr = a; wdata = d; wr = 1'b1;
        @(negedge clk); wr = 1'b0;
    endtask

    task automatic pulse(input logic [31:0] e);
        @(negedge clk); evt = e;
        @(negedge clk); evt = '0;
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            nerr++; nchk++;
            $display("FAIL watchdog act=hung exp=finished");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk("R1 irq", {31'd0, irq}, 32'd0);
        do_rd(3'd0, v); chk("R1 mode", v, 32'd0);
        do_rd(3'd1, v); chk("R1 cause", v, 32'd0);
        do_rd(3'd2, v); chk("R1 masked", v, 32'd0);
        do_rd(3'd4, v); chk("R1 mask", v, 32'hFFFF_FFFF);

        // R2 / R7 per-bit sweep: latch, masked irq stays low, W1C clears
        for (int i = 0; i < 32; i++) begin
            pulse(32'd1 << i);
            chk("R2 irq masked", {31'd0, irq}, 32'd0);
            do_rd(3'd1, v); chk("R2 latch", v, 32'd1 << i);
            do_rd(3'd1, v); chk("R7 read no clear", v, 32'd1 << i);
            do_wr(3'd1, 32'd1 << i);
            do_rd(3'd1, v); chk("R7 w1c", v, 32'd0);
        end

        // R5 mask clear sweep
        for (int i = 0; i < 32; i++) begin
            do_wr(3'd6, 32'd1 << i);
            do_rd(3'd4, v); chk("R5 mask clr", v, 32'(~((64'd2 << i) - 64'd1)));
        end
        // R4 mask set sweep on even bits
        for (int i = 0; i < 32; i += 2) begin
            do_wr(3'd5, 32'd1 << i);
            do_rd(3'd4, v); chk("R4 mask set", v, 32'h5555_5555 & 32'((64'd2 << i) - 64'd1));
        end

        // R3 direct mask write, masked view, irq
        do_wr(3'd4, 32'h0000_FFFF);
        do_rd(3'd4, v); chk("R3 mask rw", v, 32'h0000_FFFF);
        pulse(32'd1 << 20);
        chk("R2 irq", {31'd0, irq}, 32'd1);
        do_rd(3'd2, v); chk("R3 masked", v, 32'd1 << 20);
        pulse(32'd1 << 3);
        do_rd(3'd2, v); chk("R3 masked hides", v, 32'd1 << 20);
        do_rd(3'd1, v); chk("R3 cause", v, 32'h0010_0008);
        do_wr(3'd2, 32'd1 << 20);
        do_rd(3'd1, v); chk("R7 w1c via masked", v, 32'h0000_0008);
        chk("R2 irq low", {31'd0, irq}, 32'd0);
        do_wr(3'd1, 32'h8);

        // R6 cause set and write-only reads
        do_wr(3'd3, 32'hA5A5_0000);
        do_rd(3'd1, v); chk("R6 set", v, 32'hA5A5_0000);
        for (int a = 3; a < 8; a++) begin
            if (a != 4) begin
                do_rd(3'(a), v); chk("R6 read zero", v, 32'd0);
            end
        end
        do_wr(3'd1, 32'hFFFF_FFFF);
        do_rd(3'd1, v); chk("R7 w1c all", v, 32'd0);

        // R8 clear-on-read upper half
        do_wr(3'd0, 32'hFFFF_0000);
        do_rd(3'd0, v); chk("R7 mode rw", v, 32'hFFFF_0000);
        do_wr(3'd3, 32'hFFFF_FFFF);
        do_wr(3'd1, 32'hFFFF_FFFF);
        do_rd(3'd1, v); chk("R8 write ignored", v, 32'hFFFF_0000);
        do_rd(3'd1, v); chk("R8 cor", v, 32'd0);

        // R9 read of masked view clears only returned bits
        do_wr(3'd0, 32'hFFFF_FFFF);
        do_wr(3'd4, 32'hFF00_FF00);
        do_wr(3'd3, 32'h0000_FFFF);
        do_rd(3'd2, v); chk("R9 masked read", v, 32'h0000_00FF);
        do_rd(3'd1, v); chk("R9 masked kept", v, 32'h0000_FF00);
        do_rd(3'd1, v); chk("R9 cleared", v, 32'd0);

        // R10 collisions, low half W1C, high half COR
        do_wr(3'd0, 32'hFFFF_0000);
        @(negedge clk); addr = 3'd1; wdata = 32'h4; wr = 1'b1; evt = 32'h4;
        @(negedge clk); wr = 1'b0; evt = '0;
        do_rd(3'd1, v); chk("R10 w1c vs event", v, 32'h4);
        do_wr(3'd3, 32'h0010_0000);
        @(negedge clk); addr = 3'd1; rd = 1'b1; evt = 32'h0010_0000;
        @(negedge clk); rd = 1'b0; evt = '0; v = rdata;
        chk("R11 old value", v, 32'h0010_0004);
        do_rd(3'd1, v); chk("R10 cor vs event", v, 32'h0010_0004);
        do_rd(3'd1, v); chk("R8 cor after", v, 32'h4);

        done = 1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule